// File: doc/BRIEF.md
# Clock-Loss Supervisor with Self-Clock Fallback

This block decides how a device reacts when its crystal oscillator stops while it is parked in a low-power wait state. A digital failure indication from an analog clock monitor arrives each cycle, together with a per-cycle oscillator tick. Three enables pick the reaction: ignore the loss, request a clock-monitor reset at once, or fall back to a self-clock mode. In self-clock mode the PLL drives the system and a sticky interrupt flag is raised. The block then runs oscillator quality checks until the oscillator has run cleanly for a full window.

Software enters wait with a single-cycle request. Wait is left on a wakeup event, on an external reset request, or on the self-clock flag when its interrupt enable is set. If the oscillator has already been judged good, the system clock is the oscillator after the exit. Otherwise the block stays in self-clock mode on the PLL and keeps checking after the exit. The analog monitor, the oscillator and the PLL are outside the block.

Top module: `clkLossSupervisor`

## Requirements
- R1: After reset the block is running (not in wait). scmActive, scmFlag, cmRstReq, waitExit and rstSeqStart are 0, pllEn and vregEn are 1, and sysClkSelPll is 0.
- R2: With cmEn=0, cmFail in wait is ignored: no reset request, no self-clock mode, and the block stays in wait.
- R3: With cmEn=1 and scmEn=0, cmFail in wait (self-clock inactive) produces a one-cycle cmRstReq in the next cycle. The block leaves wait without a waitExit pulse.
- R4: With cmEn=1 and scmEn=1, cmFail in wait sets scmActive and scmFlag in the next cycle. While scmActive=1, sysClkSelPll=1 (1 = PLL, 0 = oscillator) and pllEn=1.
- R5: scmFlag stays set until a cycle with scmFlagClr=1. A flag set and a clear in the same cycle leave the flag at 1.
- R6: In wait, scmFlag=1 with scmIntEn=1 causes a wait exit. With scmIntEn=0 the flag alone never exits wait.
- R7: scmActive falls one cycle after the QUAL_CYCLES-th oscTick cycle with cmFail=0 counted since the last cmFail cycle. A cmFail cycle restarts the count at zero.
- R8: vregEn is always 1. pllEn is 0 only in wait with self-clock inactive and pllOffInWait=1; otherwise it is 1.
- R9: A wait exit gives a one-cycle waitExit in the next cycle. When the cause includes extRst, rstSeqStart pulses in that same cycle.
- R10: Leaving wait while self-clock mode is active keeps sysClkSelPll=1, and quality checking continues outside wait until scmActive falls.
- R11: A clock-monitor reset takes precedence over a simultaneous wait-exit cause: cmRstReq pulses and waitExit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmFail | input | 1 | Clock monitor reports oscillator failure |
| oscTick | input | 1 | One oscillator cycle elapsed (quality count step) |
| cmEn | input | 1 | Clock monitor enable |
| scmEn | input | 1 | Self-clock mode enable |
| scmIntEn | input | 1 | Self-clock interrupt enable |
| pllOffInWait | input | 1 | Switch PLL off in wait when self-clock is inactive |
| waitReq | input | 1 | One-cycle request to enter wait |
| wakeEvt | input | 1 | Wakeup event |
| extRst | input | 1 | External reset request |
| scmFlagClr | input | 1 | Write-one-to-clear for the self-clock flag |
| cmRstReq | output | 1 | One-cycle clock-monitor reset request |
| scmActive | output | 1 | Self-clock mode active |
| sysClkSelPll | output | 1 | System clock select, 1 = PLL, 0 = oscillator |
| pllEn | output | 1 | PLL enable |
| vregEn | output | 1 | Regulator enable |
| scmFlag | output | 1 | Sticky self-clock interrupt flag |
| waitExit | output | 1 | One-cycle wait-exit strobe |
| rstSeqStart | output | 1 | One-cycle reset-sequence start |

## Verification
Two events can fall in the same cycle: entry into self-clock mode, which sets the flag, and a software write that clears that flag. The bench provokes this by raising cmFail and scmFlagClr together while in wait. It judges the outcome by the flag reading 1 in the next cycle, and a cycle model in the bench repeats this check whenever random stimulus lines the two up again.

// File: rtl/clkSupPkg.sv
`timescale 1ns/1ps
package clkSupPkg;
  typedef enum logic {stRun, stWait} supState_t;

  // strobes from control to the quality datapath
  typedef struct packed {
    logic startCheck;  // begin a fresh quality window
    logic checkOn;     // self-clock mode active, count oscillator ticks
  } ctlStrobe_t;
endpackage

// File: rtl/clkSupQual.sv
`timescale 1ns/1ps
module clkSupQual import clkSupPkg::*; #(
  parameter int QUAL_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  input  logic       cmFail,
  input  logic       oscTick,
  output logic       qualityDone
);
  localparam int CW = (QUAL_CYCLES > 1) ? $clog2(QUAL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] qCnt;

  assign qualityDone = ctl.checkOn && oscTick && !cmFail && (qCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qCnt <= '0;
    end else if (ctl.startCheck || cmFail) begin
      qCnt <= '0;
    end else if (ctl.checkOn && oscTick) begin
      qCnt <= qualityDone ? '0 : qCnt + 1'b1;
    end
  end

  // R7: a failure cycle restarts the window
  a_r7_fail_restart: assert property (@(posedge clk) disable iff (!rstN)
    cmFail |=> (qCnt == '0));

  // R7: a new check always starts from zero
  a_r7_start_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.startCheck |=> (qCnt == '0));

  // R7: no counting while self-clock mode is off
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.checkOn && !ctl.startCheck && !cmFail) |=> $stable(qCnt));
endmodule

// File: rtl/clkSupCtrl.sv
`timescale 1ns/1ps
module clkSupCtrl import clkSupPkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmFail,
  input  logic       cmEn,
  input  logic       scmEn,
  input  logic       scmIntEn,
  input  logic       pllOffInWait,
  input  logic       waitReq,
  input  logic       wakeEvt,
  input  logic       extRst,
  input  logic       scmFlagClr,
  input  logic       qualityDone,
  output ctlStrobe_t ctl,
  output logic       cmRstReq,
  output logic       scmActive,
  output logic       sysClkSelPll,
  output logic       pllEn,
  output logic       vregEn,
  output logic       scmFlag,
  output logic       waitExit,
  output logic       rstSeqStart
);
  supState_t state;
  logic inWait, lossSeen, lossRst, lossScm, exitNow;

  assign inWait   = (state == stWait);
  assign lossSeen = inWait && !scmActive && cmFail && cmEn;
  assign lossRst  = lossSeen && !scmEn;
  assign lossScm  = lossSeen && scmEn;
  assign exitNow  = inWait && !lossRst &&
                    (wakeEvt || extRst || (scmFlag && scmIntEn));

  assign ctl.startCheck = lossScm;
  assign ctl.checkOn    = scmActive;

  assign sysClkSelPll = scmActive;
  assign pllEn        = scmActive || !(inWait && pllOffInWait);
  assign vregEn       = 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= stRun;
      scmActive   <= 1'b0;
      scmFlag     <= 1'b0;
      cmRstReq    <= 1'b0;
      waitExit    <= 1'b0;
      rstSeqStart <= 1'b0;
    end else begin
      cmRstReq    <= lossRst;
      waitExit    <= exitNow;
      rstSeqStart <= exitNow && extRst;

      unique case (state)
        stRun:   if (waitReq) state <= stWait;
        stWait:  if (lossRst || exitNow) state <= stRun;
        default: state <= stRun;
      endcase

      if (lossScm)          scmActive <= 1'b1;
      else if (qualityDone) scmActive <= 1'b0;

      if (lossScm)         scmFlag <= 1'b1;
      else if (scmFlagClr) scmFlag <= 1'b0;
    end
  end

  a_r3_rst_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmRstReq |=> !cmRstReq);

  a_r9_exit_pulse: assert property (@(posedge clk) disable iff (!rstN)
    waitExit |=> !waitExit);

  a_r9_rss_with_exit: assert property (@(posedge clk) disable iff (!rstN)
    rstSeqStart |-> waitExit);

  a_r11_rst_no_exit: assert property (@(posedge clk) disable iff (!rstN)
    cmRstReq |-> !waitExit);

  a_r4_flag_with_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(scmActive) |-> scmFlag);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (scmFlag && !scmFlagClr) |=> scmFlag);

  a_r2_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (inWait && !cmEn && !wakeEvt && !extRst && !(scmFlag && scmIntEn)) |=> !cmRstReq && !waitExit);
endmodule

// File: rtl/clkLossSupervisor.sv
`timescale 1ns/1ps
module clkLossSupervisor #(
  parameter int QUAL_CYCLES = 4096
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmFail,
  input  logic oscTick,
  input  logic cmEn,
  input  logic scmEn,
  input  logic scmIntEn,
  input  logic pllOffInWait,
  input  logic waitReq,
  input  logic wakeEvt,
  input  logic extRst,
  input  logic scmFlagClr,
  output logic cmRstReq,
  output logic scmActive,
  output logic sysClkSelPll,
  output logic pllEn,
  output logic vregEn,
  output logic scmFlag,
  output logic waitExit,
  output logic rstSeqStart
);
  clkSupPkg::ctlStrobe_t ctl;
  logic qualityDone;

  clkSupCtrl uCtrl (
    .clk(clk), .rstN(rstN), .cmFail(cmFail), .cmEn(cmEn), .scmEn(scmEn),
    .scmIntEn(scmIntEn), .pllOffInWait(pllOffInWait), .waitReq(waitReq),
    .wakeEvt(wakeEvt), .extRst(extRst), .scmFlagClr(scmFlagClr),
    .qualityDone(qualityDone), .ctl(ctl), .cmRstReq(cmRstReq),
    .scmActive(scmActive), .sysClkSelPll(sysClkSelPll), .pllEn(pllEn),
    .vregEn(vregEn), .scmFlag(scmFlag), .waitExit(waitExit),
    .rstSeqStart(rstSeqStart)
  );

  clkSupQual #(.QUAL_CYCLES(QUAL_CYCLES)) uQual (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmFail(cmFail), .oscTick(oscTick),
    .qualityDone(qualityDone)
  );
endmodule

// File: tb/sim_clkLossSupervisor.sv
`timescale 1ns/1ps
module sim_clkLossSupervisor;
  localparam int QN = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmFail = 0, oscTick = 0, cmEn = 0, scmEn = 0, scmIntEn = 0;
  logic pllOffInWait = 0, waitReq = 0, wakeEvt = 0, extRst = 0, scmFlagClr = 0;
  logic cmRstReq, scmActive, sysClkSelPll, pllEn, vregEn, scmFlag, waitExit, rstSeqStart;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  clkLossSupervisor #(.QUAL_CYCLES(QN)) u0 (
    .clk(clk), .rstN(rstN), .cmFail(cmFail), .oscTick(oscTick), .cmEn(cmEn),
    .scmEn(scmEn), .scmIntEn(scmIntEn), .pllOffInWait(pllOffInWait),
    .waitReq(waitReq), .wakeEvt(wakeEvt), .extRst(extRst),
    .scmFlagClr(scmFlagClr), .cmRstReq(cmRstReq), .scmActive(scmActive),
    .sysClkSelPll(sysClkSelPll), .pllEn(pllEn), .vregEn(vregEn),
    .scmFlag(scmFlag), .waitExit(waitExit), .rstSeqStart(rstSeqStart)
  );

  // cycle model built from the requirements
  bit mWait, mScm, mFlag, mRst, mExit, mRss;
  int mCnt;

  function automatic bit expPll(bit w, bit s, bit off);
    return s || !(w && off);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mWait = 0; mScm = 0; mFlag = 0; mRst = 0; mExit = 0; mRss = 0; mCnt = 0;
    end else begin
      bit done, lRst, lScm, ex;
      done = mScm && oscTick && !cmFail && (mCnt == QN - 1);
      lRst = mWait && !mScm && cmFail && cmEn && !scmEn;
      lScm = mWait && !mScm && cmFail && cmEn && scmEn;
      ex   = mWait && !lRst && (wakeEvt || extRst || (mFlag && scmIntEn));
      mRst = lRst; mExit = ex; mRss = ex && extRst;
      if (!mWait && waitReq) mWait = 1;
      else if (mWait && (lRst || ex)) mWait = 0;
      if (lScm || cmFail) mCnt = 0;
      else if (mScm && oscTick) mCnt = done ? 0 : mCnt + 1;
      if (lScm) mScm = 1; else if (done) mScm = 0;
      if (lScm) mFlag = 1; else if (scmFlagClr) mFlag = 0;
    end
  end

  task automatic chkv(string tag, string nm, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
    end
  endtask

  task automatic compareModel();
    chkv("R3", "cmRstReq", int'(cmRstReq), int'(mRst));
    chkv("R7", "scmActive", int'(scmActive), int'(mScm));
    chkv("R5", "scmFlag", int'(scmFlag), int'(mFlag));
    chkv("R9", "waitExit", int'(waitExit), int'(mExit));
    chkv("R9", "rstSeqStart", int'(rstSeqStart), int'(mRss));
    chkv("R8", "pllEn", int'(pllEn), int'(expPll(mWait, mScm, pllOffInWait)));
    chkv("R10", "sysClkSelPll", int'(sysClkSelPll), int'(mScm));
    chkv("R8", "vregEn", int'(vregEn), 1);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compareModel();
  endtask

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkv("R1", "scmActive", int'(scmActive), 0);
    chkv("R1", "scmFlag", int'(scmFlag), 0);
    chkv("R1", "cmRstReq", int'(cmRstReq), 0);
    chkv("R1", "waitExit", int'(waitExit), 0);
    chkv("R1", "rstSeqStart", int'(rstSeqStart), 0);
    chkv("R1", "pllEn", int'(pllEn), 1);
    chkv("R1", "vregEn", int'(vregEn), 1);
    chkv("R1", "sysClkSelPll", int'(sysClkSelPll), 0);

    // R2 loss ignored with monitor disabled, R8 PLL off in wait
    pllOffInWait = 1; waitReq = 1; tick(); waitReq = 0;
    chkv("R8", "pllEn in wait", int'(pllEn), 0);
    cmFail = 1; repeat (3) tick(); cmFail = 0;
    chkv("R2", "cmRstReq", int'(cmRstReq), 0);
    chkv("R2", "scmActive", int'(scmActive), 0);
    chkv("R2", "still in wait", int'(pllEn), 0);

    // R9 wake exit
    wakeEvt = 1; tick(); wakeEvt = 0;
    chkv("R9", "waitExit", int'(waitExit), 1);
    chkv("R9", "rstSeqStart", int'(rstSeqStart), 0);
    tick();
    chkv("R9", "waitExit pulse end", int'(waitExit), 0);
    chkv("R8", "pllEn after exit", int'(pllEn), 1);

    // R3 immediate reset, R11 beats a simultaneous wake
    cmEn = 1; waitReq = 1; tick(); waitReq = 0;
    cmFail = 1; wakeEvt = 1; tick(); cmFail = 0; wakeEvt = 0;
    chkv("R3", "cmRstReq", int'(cmRstReq), 1);
    chkv("R11", "waitExit", int'(waitExit), 0);
    tick();
    chkv("R3", "cmRstReq pulse end", int'(cmRstReq), 0);
    chkv("R3", "left wait", int'(pllEn), 1);

    // R4 self-clock entry, R6 no exit without interrupt enable
    scmEn = 1; waitReq = 1; tick(); waitReq = 0;
    cmFail = 1; tick(); cmFail = 0;
    chkv("R4", "scmActive", int'(scmActive), 1);
    chkv("R4", "scmFlag", int'(scmFlag), 1);
    chkv("R4", "sysClkSelPll", int'(sysClkSelPll), 1);
    chkv("R4", "pllEn", int'(pllEn), 1);
    repeat (5) tick();
    chkv("R6", "no exit", int'(waitExit), 0);
    chkv("R5", "flag sticky", int'(scmFlag), 1);

    // R7 quality window with restart
    oscTick = 1;
    repeat (QN - 1) tick();
    chkv("R7", "active before window end", int'(scmActive), 1);
    cmFail = 1; tick(); cmFail = 0;
    repeat (QN - 1) tick();
    chkv("R7", "active after restart", int'(scmActive), 1);
    tick();
    chkv("R7", "good after full window", int'(scmActive), 0);
    chkv("R8", "pllEn off in wait", int'(pllEn), 0);
    chkv("R6", "stays in wait", int'(waitExit), 0);

    // R6 flag exit with interrupt enable, R5 clear
    scmIntEn = 1; tick(); scmIntEn = 0;
    chkv("R6", "flag exit", int'(waitExit), 1);
    scmFlagClr = 1; tick(); scmFlagClr = 0;
    chkv("R5", "flag cleared", int'(scmFlag), 0);

    // R10 exit while self-clock active
    waitReq = 1; tick(); waitReq = 0;
    oscTick = 0; cmFail = 1; tick(); cmFail = 0;
    wakeEvt = 1; tick(); wakeEvt = 0;
    chkv("R10", "waitExit", int'(waitExit), 1);
    chkv("R10", "sysClkSelPll stays", int'(sysClkSelPll), 1);
    oscTick = 1;
    repeat (QN - 1) tick();
    chkv("R10", "checking in run", int'(sysClkSelPll), 1);
    tick();
    chkv("R10", "oscillator selected", int'(sysClkSelPll), 0);

    // R5 set and clear in the same cycle
    scmFlagClr = 1; tick(); scmFlagClr = 0;
    waitReq = 1; tick(); waitReq = 0;
    cmFail = 1; scmFlagClr = 1; tick(); cmFail = 0; scmFlagClr = 0;
    chkv("R5", "set wins over clear", int'(scmFlag), 1);
    wakeEvt = 1; tick(); wakeEvt = 0;
    repeat (QN + 4) tick();

    // R9 external reset exit
    waitReq = 1; tick(); waitReq = 0;
    extRst = 1; tick(); extRst = 0;
    chkv("R9", "waitExit on extRst", int'(waitExit), 1);
    chkv("R9", "rstSeqStart", int'(rstSeqStart), 1);
    tick();
    chkv("R9", "rstSeqStart end", int'(rstSeqStart), 0);

    // random phase checked against the cycle model
    begin
      int failLeft = 0;
      for (int i = 0; i < 40000; i++) begin
        if (i % 3000 == 0) begin
          cmEn = 1'($urandom % 4 != 0);
          scmEn = 1'($urandom % 3 != 0);
          scmIntEn = 1'($urandom % 2);
          pllOffInWait = 1'($urandom % 2);
        end
        if (failLeft == 0 && ($urandom % 5000) == 0) failLeft = int'($urandom % 20) + 1;
        if (failLeft > 0) begin
          cmFail = 1'($urandom % 4 != 0);
          failLeft--;
        end else cmFail = 0;
        oscTick = 1'($urandom % 8 != 0);
        waitReq = 1'($urandom % 50 == 0);
        wakeEvt = 1'($urandom % 2500 == 0);
        extRst = 1'($urandom % 4000 == 0);
        scmFlagClr = 1'($urandom % 700 == 0);
        tick();
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule